// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero Bus Turnaround

This block is a synthesizable behavioural model of a 36-bit-wide synchronous SRAM whose read and write paths share one pipeline latency. Because both directions use the same latency, a bus master can issue a read, then a write, then a read on consecutive clock edges without inserting idle cycles. Every control and data input is registered on the rising clock edge. A single active-low clock enable freezes the whole pipeline. The output enable and the snooze input act without waiting for a clock edge.

A transfer begins on a load cycle, with `adv_load` low. The address, the read/write select, the three chip selects and the byte-lane enables are captured on that edge. On the following cycles, with `adv_load` high, the same operation continues through a 4-beat burst. The burst addresses come from an internal 2-bit counter. A static input picks the burst order: either a wrapping increment or an XOR sequence.

Read data appears on a registered output two enabled edges after the address edge. Write data is taken from `din` two enabled edges after its address edge. A read that follows close behind a write to the same word still returns the newest data, merged lane by lane.

Top module: `psram_pipe`

## Requirements
- R1: A read loaded on enabled edge N drives its word on `rd_data` with `rd_drive` high after enabled edge N+2. A write loaded on enabled edge N takes its data from `din` at enabled edge N+2.
- R2: Reads and writes may alternate on every cycle with no idle cycles. A read returns the newest contents of its address, including data from a write issued on the cycle just before it.
- R3: Byte lane i is bits 9i+8 down to 9i. A write stores lane i only when `lane_wr_n[i]` is 0 on that beat's edge; the other lanes keep their old contents, and a write with all four bits at 1 changes nothing.
- R4: A load cycle selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination, and any write, leaves `rd_drive` low for that slot. A deselected burst stays deselected on its advance beats.
- R5: On a cycle with `adv_load` high, the operation of the last load continues, and the inputs `rw_n`, the chip selects and `addr` are ignored. With `burst_intlv`=0, beat k (k=0..3) uses the low two address bits (start+k) mod 4. The upper address bits stay fixed, and a fifth beat wraps to the start.
- R6: With `burst_intlv`=1, beat k uses the low two address bits start XOR k.
- R7: An edge with `clk_en_n` high is ignored: nothing is sampled, nothing is written, and `rd_data` and the pipeline hold.
- R8: `out_en_n` high forces `rd_drive` low at once, without a clock edge, and leaves the pipeline untouched. When it returns low, the held word is driven again.
- R9: `snooze` high forces `rd_drive` low at once and makes edges act as with `clk_en_n` high. When it is released, the held word is driven again and memory is unchanged.
- R10: While `rst_n` is low, `rd_drive` is low and `rd_data` is zero, and any operation in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| adv_load | input | 1 | 0 = load a new operation, 1 = advance the current burst |
| addr | input | AW | Word address (AW = clog2(DEPTH)) |
| rw_n | input | 1 | 1 = read, 0 = write (sampled on load cycles) |
| lane_wr_n | input | 4 | Active-low write enable per 9-bit byte lane |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| burst_intlv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| din | input | 36 | Write data, taken two enabled edges after its address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Power-down: disables output and freezes the pipeline |
| rd_data | output | 36 | Registered read data |
| rd_drive | output | 1 | High when `rd_data` is being driven onto the bus |

## Verification
On every cycle, the bound checker checks three things: that a selected read load produces a valid output slot exactly two enabled edges later, that a write or deselect load produces an empty slot, and that a frozen edge leaves the output register and its valid flag unchanged. It also checks that the output word only moves when a read slot lands. Only the bench scenarios can show the data contents: newest-value return for back-to-back read-after-write, lane merging through partial and fully masked writes, both burst address orders including the wrap, and that stalled or snoozed writes never reach memory.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BCNT_W  = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen
  import psram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam logic [BCNT_W-1:0] ONE = BCNT_W'(1);

  logic [AW-1:0]     base_q, base_d;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic [BCNT_W-1:0] beat, low;

  always_comb begin
    beat = cnt_q + ONE;
    if (interleave) low = base_q[BCNT_W-1:0] ^ beat;
    else            low = base_q[BCNT_W-1:0] + beat;
    if (load) begin
      addr_out = addr_in;
      base_d   = addr_in;
      cnt_d    = '0;
    end else begin
      addr_out = {base_q[AW-1:BCNT_W], low};
      base_d   = base_q;
      cnt_d    = beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import psram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  wbe,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en && we && wbe[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (en && re)           rd_q       <= mem[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_fwd_merge.sv
module sram_fwd_merge
  import psram_pkg::*;
(
  input  logic              hit,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] fwd_word,
  output logic [WORD_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && be[g]) ? fwd_word[g*LANE_W +: LANE_W]
                                                       : mem_word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/psram_pipe.sv
module psram_pipe
  import psram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv_load,
  input  logic [AW-1:0]     addr,
  input  logic              rw_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              burst_intlv,
  input  logic [WORD_W-1:0] din,
  input  logic              out_en_n,
  input  logic              snooze,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_drive
);
  logic              en, load, sel;
  op_e               new_op, op_cur_q, op_cur_d;
  logic [AW-1:0]     beat_addr;

  op_e               s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [AW-1:0]     s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [LANES-1:0]  s1_be_q, s1_be_d, s2_be_q, s2_be_d;

  logic              lw_valid_q, lw_valid_d;
  logic [AW-1:0]     lw_addr_q, lw_addr_d;
  logic [LANES-1:0]  lw_be_q, lw_be_d;
  logic [WORD_W-1:0] lw_data_q, lw_data_d;

  logic [WORD_W-1:0] arr_rdata, merged;
  logic              fwd_hit, arr_we, arr_re;
  logic [WORD_W-1:0] dout_q, dout_d;
  logic              rd_valid_q, rd_valid_d;

  // Control decode and stage-1 next state
  always_comb begin
    en   = ~clk_en_n & ~snooze;
    load = ~adv_load;
    sel  = ~cs1_n & cs2 & ~cs3_n;
    if (!sel)      new_op = OP_NONE;
    else if (rw_n) new_op = OP_RD;
    else           new_op = OP_WR;
    op_cur_d  = load ? new_op : op_cur_q;
    s1_op_d   = op_cur_d;
    s1_addr_d = beat_addr;
    s1_be_d   = ~lane_wr_n;
  end

  // Stage-2 and last-write next state
  always_comb begin
    s2_op_d    = s1_op_q;
    s2_addr_d  = s1_addr_q;
    s2_be_d    = s1_be_q;
    lw_valid_d = (s2_op_q == OP_WR);
    lw_addr_d  = s2_addr_q;
    lw_be_d    = s2_be_q;
    lw_data_d  = din;
  end

  assign arr_we  = (s2_op_q == OP_WR);
  assign arr_re  = (s1_op_q == OP_RD);
  assign fwd_hit = lw_valid_q && (lw_addr_q == s2_addr_q);

  // Output stage next state
  always_comb begin
    rd_valid_d = (s2_op_q == OP_RD);
    dout_d     = rd_valid_d ? merged : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cur_q   <= OP_NONE;
      s1_op_q    <= OP_NONE;
      s1_addr_q  <= '0;
      s1_be_q    <= '0;
      s2_op_q    <= OP_NONE;
      s2_addr_q  <= '0;
      s2_be_q    <= '0;
      lw_valid_q <= 1'b0;
      lw_addr_q  <= '0;
      lw_be_q    <= '0;
      lw_data_q  <= '0;
      dout_q     <= '0;
      rd_valid_q <= 1'b0;
    end else if (en) begin
      op_cur_q   <= op_cur_d;
      s1_op_q    <= s1_op_d;
      s1_addr_q  <= s1_addr_d;
      s1_be_q    <= s1_be_d;
      s2_op_q    <= s2_op_d;
      s2_addr_q  <= s2_addr_d;
      s2_be_q    <= s2_be_d;
      lw_valid_q <= lw_valid_d;
      lw_addr_q  <= lw_addr_d;
      lw_be_q    <= lw_be_d;
      lw_data_q  <= lw_data_d;
      dout_q     <= dout_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  sram_burst_gen #(.AW(AW)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .load       (load),
    .interleave (burst_intlv),
    .addr_in    (addr),
    .addr_out   (beat_addr)
  );

  sram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk   (clk),
    .en    (en),
    .we    (arr_we),
    .wbe   (s2_be_q),
    .waddr (s2_addr_q),
    .wdata (din),
    .re    (arr_re),
    .raddr (s1_addr_q),
    .rdata (arr_rdata)
  );

  sram_fwd_merge u_merge (
    .hit      (fwd_hit),
    .be       (lw_be_q),
    .mem_word (arr_rdata),
    .fwd_word (lw_data_q),
    .merged   (merged)
  );

  assign rd_data  = dout_q;
  assign rd_drive = rd_valid_q & ~out_en_n & ~snooze;
endmodule

// File: rtl/psram_pipe_chk.sv
module psram_pipe_chk
  import psram_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              snooze,
  input logic              adv_load,
  input logic              rw_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid
);
  logic       en, ld_rd, ld_other;
  logic [1:0] cyc_q;

  assign en       = ~clk_en_n & ~snooze;
  assign ld_rd    = en & ~adv_load & (~cs1_n & cs2 & ~cs3_n) & rw_n;
  assign ld_other = en & ~adv_load & ~((~cs1_n & cs2 & ~cs3_n) & rw_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)   cyc_q <= cyc_q + 2'd1;
  end

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && en && $past(en) && $past(ld_rd, 2)) |=> rd_valid);

  assert_nonread_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && en && $past(en) && $past(ld_other, 2)) |=> !rd_valid);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && !en) |=> ($stable(rd_data) && $stable(rd_valid)));

  assert_data_moves_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && !$stable(rd_data)) |-> rd_valid);
endmodule

bind psram_pipe psram_pipe_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .snooze   (snooze),
  .adv_load (adv_load),
  .rw_n     (rw_n),
  .cs1_n    (cs1_n),
  .cs2      (cs2),
  .cs3_n    (cs3_n),
  .rd_data  (rd_data),
  .rd_valid (rd_valid_q)
);

// File: tb/tb_psram_pipe.sv
module tb_psram_pipe;
  import psram_pkg::*;

  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam logic [2:0] SEL   = 3'b010;
  localparam logic [2:0] DESEL = 3'b110;
  localparam logic [35:0] Z  = 36'h0;
  localparam logic [35:0] D0 = {9'h111, 9'h122, 9'h133, 9'h144};
  localparam logic [35:0] D1 = {9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD};
  localparam logic [35:0] D2 = 36'h0F0F0F0F0;
  localparam logic [35:0] D3 = 36'h5A5A5A5A5;
  localparam logic [35:0] M01 = {D0[35:18], D1[17:0]};
  localparam logic [35:0] M10 = {D1[35:18], D0[17:0]};

  typedef struct packed {
    logic        adv;
    logic        rwn;
    logic [3:0]  bwn;
    logic [2:0]  cs;
    logic [7:0]  a;
    logic [35:0] d;
    logic [1:0]  md;
    logic [35:0] ex;
  } vec_t;

  // md: 0 no check, 1 expect driven data ex, 2 expect no drive
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 4'h0, SEL,      8'h20, Z,  2'd0, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h20, Z,  2'd1, D0},
    '{1'b0, 1'b0, 4'hC, SEL,      8'h20, D0, 2'd0, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h20, Z,  2'd1, M01},
    '{1'b0, 1'b1, 4'hF, 3'b110,   8'h00, D1, 2'd2, Z},
    '{1'b0, 1'b1, 4'hF, 3'b000,   8'h00, Z,  2'd2, Z},
    '{1'b0, 1'b0, 4'h0, SEL,      8'h30, Z,  2'd0, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h20, Z,  2'd1, M01},
    '{1'b0, 1'b0, 4'hF, SEL,      8'h30, D2, 2'd0, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h30, Z,  2'd1, D2},
    '{1'b0, 1'b1, 4'hF, 3'b011,   8'h30, D3, 2'd2, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h30, Z,  2'd1, D2},
    '{1'b0, 1'b0, 4'h0, SEL,      8'h31, Z,  2'd0, Z},
    '{1'b0, 1'b0, 4'h3, SEL,      8'h31, Z,  2'd0, Z},
    '{1'b0, 1'b1, 4'hF, SEL,      8'h31, D0, 2'd1, M10},
    '{1'b0, 1'b1, 4'hF, 3'b110,   8'h00, D1, 2'd2, Z}
  };

  logic          clk, rst_n, clk_en_n, adv_load, rw_n, cs1_n, cs2, cs3_n;
  logic          burst_intlv, out_en_n, snooze, rd_drive;
  logic [AW-1:0] addr;
  logic [3:0]    lane_wr_n;
  logic [35:0]   din, rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0]  p1_md, p2_md;
  logic [35:0] p1_ex, p2_ex;
  string       p1_rq, p2_rq;

  psram_pipe #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_load(adv_load),
    .addr(addr), .rw_n(rw_n), .lane_wr_n(lane_wr_n), .cs1_n(cs1_n),
    .cs2(cs2), .cs3_n(cs3_n), .burst_intlv(burst_intlv), .din(din),
    .out_en_n(out_en_n), .snooze(snooze), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [35:0] val(input logic [7:0] a);
    return {1'b0, a, 1'b1, a ^ 8'h5A, 1'b0, a + 8'd3, 1'b1, ~a};
  endfunction

  task automatic expect_ok(input bit ok, input string rq,
                           input logic [36:0] act, input logic [36:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual {drive,data}=%h expected %h", rq, act, exp);
    end
  endtask

  task automatic check_slot(input logic [1:0] md, input logic [35:0] ex, input string rq);
    if (md == 2'd1)
      expect_ok(rd_drive === 1'b1 && rd_data === ex, rq, {rd_drive, rd_data}, {1'b1, ex});
    else if (md == 2'd2)
      expect_ok(rd_drive === 1'b0, rq, {rd_drive, rd_data}, {1'b0, rd_data});
  endtask

  task automatic clear_slots();
    p1_md = 2'd0; p2_md = 2'd0; p1_ex = Z; p2_ex = Z; p1_rq = ""; p2_rq = "";
  endtask

  // One enabled cycle; the expectation given here is checked two calls later.
  task automatic cyc(input logic adv, input logic rwn, input logic [3:0] bwn,
                     input logic [2:0] cs, input logic [7:0] a, input logic [35:0] d,
                     input logic [1:0] md, input logic [35:0] ex, input string rq);
    adv_load = adv; rw_n = rwn; lane_wr_n = bwn; {cs1_n, cs2, cs3_n} = cs;
    addr = a; din = d;
    @(posedge clk); #2;
    check_slot(p2_md, p2_ex, p2_rq);
    p2_md = p1_md; p2_ex = p1_ex; p2_rq = p1_rq;
    p1_md = md;    p1_ex = ex;    p1_rq = rq;
  endtask

  task automatic idle(input logic [35:0] d);
    cyc(1'b0, 1'b1, 4'hF, DESEL, 8'h00, d, 2'd0, Z, "");
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; adv_load = 1'b0; rw_n = 1'b1; cs1_n = 1'b1;
    cs2 = 1'b0; cs3_n = 1'b1; burst_intlv = 1'b0; out_en_n = 1'b0; snooze = 1'b0;
    addr = '0; lane_wr_n = 4'hF; din = Z;
    clear_slots();
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    expect_ok(rd_drive === 1'b0 && rd_data === Z, "R10", {rd_drive, rd_data}, 37'h0);
    rst_n = 1'b1;

    // Table of mixed read/write streams (R1 R2 R3 R4)
    for (int i = 0; i < NV; i++)
      cyc(VEC[i].adv, VEC[i].rwn, VEC[i].bwn, VEC[i].cs, VEC[i].a, VEC[i].d,
          VEC[i].md, VEC[i].ex, (VEC[i].md == 2'd2) ? "R4" : "R1 R2 R3");
    idle(Z); idle(Z);

    // Prefill 0x40..0x43
    cyc(1'b0, 1'b0, 4'h0, SEL, 8'h40, Z, 2'd0, Z, "");
    cyc(1'b0, 1'b0, 4'h0, SEL, 8'h41, Z, 2'd0, Z, "");
    cyc(1'b0, 1'b0, 4'h0, SEL, 8'h42, val(8'h40), 2'd0, Z, "");
    cyc(1'b0, 1'b0, 4'h0, SEL, 8'h43, val(8'h41), 2'd0, Z, "");
    idle(val(8'h42)); idle(val(8'h43));

    // R5: linear burst from 0x43 with wrap; advance beats carry junk controls
    cyc(1'b0, 1'b1, 4'hF, SEL,   8'h43, Z, 2'd1, val(8'h43), "R5");
    cyc(1'b1, 1'b0, 4'h0, DESEL, 8'hEE, Z, 2'd1, val(8'h40), "R5");
    cyc(1'b1, 1'b0, 4'h0, DESEL, 8'hEE, Z, 2'd1, val(8'h41), "R5");
    cyc(1'b1, 1'b0, 4'h0, DESEL, 8'hEE, Z, 2'd1, val(8'h42), "R5");
    cyc(1'b1, 1'b0, 4'h0, DESEL, 8'hEE, Z, 2'd1, val(8'h43), "R5");
    idle(Z); idle(Z);

    // R6: interleaved bursts from 0x42 and 0x41
    burst_intlv = 1'b1;
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h42, Z, 2'd1, val(8'h42), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h43), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h40), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h41), "R6");
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h41, Z, 2'd1, val(8'h41), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h40), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h43), "R6");
    cyc(1'b1, 1'b1, 4'hF, SEL, 8'h00, Z, 2'd1, val(8'h42), "R6");
    idle(Z); idle(Z);
    burst_intlv = 1'b0;

    // R5: linear burst write from 0x81, then single reads back
    cyc(1'b0, 1'b0, 4'h0, SEL,   8'h81, Z, 2'd0, Z, "");
    cyc(1'b1, 1'b1, 4'h0, DESEL, 8'h00, Z, 2'd0, Z, "");
    cyc(1'b1, 1'b1, 4'h0, DESEL, 8'h00, val(8'h90), 2'd0, Z, "");
    cyc(1'b1, 1'b1, 4'h0, DESEL, 8'h00, val(8'h91), 2'd0, Z, "");
    idle(val(8'h92)); idle(val(8'h93));
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h81, Z, 2'd1, val(8'h90), "R5");
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h82, Z, 2'd1, val(8'h91), "R5");
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h83, Z, 2'd1, val(8'h92), "R5");
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h80, Z, 2'd1, val(8'h93), "R5");

    // R4: deselected burst stays deselected on advance beats
    cyc(1'b0, 1'b1, 4'hF, DESEL, 8'h40, Z, 2'd2, Z, "R4");
    cyc(1'b1, 1'b1, 4'hF, SEL,   8'h40, Z, 2'd2, Z, "R4");
    idle(Z); idle(Z);

    // R7: stall with a junk write load presented
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h41, Z, 2'd1, val(8'h41), "R7");
    idle(Z);
    clk_en_n = 1'b1; adv_load = 1'b0; rw_n = 1'b0; lane_wr_n = 4'h0;
    {cs1_n, cs2, cs3_n} = SEL; addr = 8'h41; din = D3;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      expect_ok(rd_drive === 1'b0, "R7", {rd_drive, rd_data}, {1'b0, rd_data});
    end
    clk_en_n = 1'b0;
    idle(Z);

    // R8: asynchronous output enable
    out_en_n = 1'b1; #1;
    expect_ok(rd_drive === 1'b0, "R8", {rd_drive, rd_data}, {1'b0, rd_data});
    out_en_n = 1'b0; #1;
    expect_ok(rd_drive === 1'b1 && rd_data === val(8'h41), "R8",
              {rd_drive, rd_data}, {1'b1, val(8'h41)});

    // R9: snooze disables output and freezes the pipeline
    snooze = 1'b1; #1;
    expect_ok(rd_drive === 1'b0, "R9", {rd_drive, rd_data}, {1'b0, rd_data});
    adv_load = 1'b0; rw_n = 1'b0; lane_wr_n = 4'h0; {cs1_n, cs2, cs3_n} = SEL;
    addr = 8'h41; din = D2;
    repeat (2) @(posedge clk);
    #2; snooze = 1'b0; #1;
    expect_ok(rd_drive === 1'b1 && rd_data === val(8'h41), "R9",
              {rd_drive, rd_data}, {1'b1, val(8'h41)});
    idle(Z);
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h41, Z, 2'd1, val(8'h41), "R7 R9");
    idle(Z); idle(Z);

    // R10: reset mid-flight drops a pending read
    cyc(1'b0, 1'b1, 4'hF, SEL, 8'h40, Z, 2'd0, Z, "");
    idle(Z);
    rst_n = 1'b0; #1;
    expect_ok(rd_drive === 1'b0 && rd_data === Z, "R10", {rd_drive, rd_data}, 37'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    clear_slots();
    cyc(1'b0, 1'b1, 4'hF, DESEL, 8'h00, Z, 2'd2, Z, "R10");
    cyc(1'b0, 1'b1, 4'hF, DESEL, 8'h00, Z, 2'd2, Z, "R10");
    expect_ok(rd_drive === 1'b0, "R10", {rd_drive, rd_data}, {1'b0, rd_data});
    idle(Z); idle(Z);

    finish_up();
  end
endmodule